// File: doc/BRIEF.md
# Dual-Slot Bus Speed Arbiter

On a board with two processor sockets, each populated socket states the front-side bus speed it supports as a 3-bit code. The two sockets must share one bus speed, so this block picks it. It reads both codes and both socket-present flags. It drives the code of the slower populated socket onto the shared bus-speed output. When only one socket is populated, it drives that socket's code instead. The speed codes do not rise in numeric order, so each code is first converted to a speed rank, and the comparison uses the ranks.

While the board powers up, the bus-speed output holds the 100 MHz code. It stays there until a reference-ready input has been seen high long enough to trust. From then on the output follows the slot inputs for as long as the block is out of reset. Two status outputs are never masked by this start-up hold. One reports that socket A is strictly faster than socket B, and the other reports equal speeds. An error flag marks a populated socket that presents the reserved code.

Top module: `fsb_speed_arbiter`

## Requirements
- R1: Codes are compared by speed, not by code value. In speed order, from lowest to highest: 101=100 MHz, 001=133, 011=166, 010=200, 000=266, 100=333, 110=400 MHz. Bit order is {bit3,bit2,bit1}.
- R2: When only socket A is present (a_present_n=0, b_present_n=1), a_faster is 0 and bus_sel equals a_code.
- R3: When only socket B is present, a_faster is 1 and bus_sel equals b_code.
- R4: When both sockets are present, the slower speed is driven, and a_faster is 1 only when A's speed is strictly above B's. At equal speeds same_speed is 1 and A's code is driven.
- R5: When neither socket is present, bus_sel is 101, a_faster is 0 and same_speed is 0.
- R6: From reset, bus_sel is held at 101 until the output is unmasked. After reset, a_faster, same_speed and code_err are 0.
- R7: Unmasking needs ref_ready high, after synchronization, for READY_HOLD consecutive cycles (default 4). A shorter pulse leaves the output masked.
- R8: Once unmasked, the output stays unmasked until reset, even if ref_ready falls.
- R9: a_faster, same_speed and code_err follow the slot inputs even while bus_sel is masked.
- R10: Code 111 is reserved and has the lowest selection priority: it ranks above every real speed, so a valid code from the other present socket is chosen. code_err is 1 whenever a present socket shows 111.
- R11: After unmasking, a change on any slot input reaches the outputs within SYNC_STAGES+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_ready | input | 1 | Asynchronous reference-ready indication |
| a_code | input | 3 | Socket A speed code |
| a_present_n | input | 1 | Socket A populated, active low |
| b_code | input | 3 | Socket B speed code |
| b_present_n | input | 1 | Socket B populated, active low |
| bus_sel | output | 3 | Shared bus speed code |
| a_faster | output | 1 | Socket A strictly faster than B (also set when only B is present) |
| same_speed | output | 1 | Both sockets present at equal speed |
| code_err | output | 1 | A present socket shows the reserved code |

## Verification
The assertions assume the slot inputs and ref_ready may change at any time. They also assume that changes reach the arbitration logic only after the synchronizer chain, so every property is phrased against registered state and never against the raw pins. The stimulus moves inputs only on the falling clock edge. It then holds them at least SYNC_STAGES+3 cycles before a result is compared, which keeps every comparison clear of the synchronizer transit. The start-up checks drive ref_ready as clean levels: one pulse shorter than the hold count, then one held level long enough to qualify.

// File: rtl/fsb_arb_pkg.sv
package fsb_arb_pkg;
   localparam int CODE_W = 3;
   localparam int RANK_W = 3;
   localparam logic [CODE_W-1:0] CODE_DEFAULT  = 3'b101;
   localparam logic [CODE_W-1:0] CODE_RESERVED = 3'b111;

   typedef struct packed {
      logic [CODE_W-1:0] code;
      logic              present;
   } slot_t;

   // Speed rank of a valid code, 0 = slowest.
   function automatic logic [RANK_W-1:0] speed_rank(input logic [CODE_W-1:0] c);
      logic [RANK_W-1:0] r;
      case (c)
         3'b101:  r = 3'd0;
         3'b001:  r = 3'd1;
         3'b011:  r = 3'd2;
         3'b010:  r = 3'd3;
         3'b000:  r = 3'd4;
         3'b100:  r = 3'd5;
         3'b110:  r = 3'd6;
         default: r = 3'd7;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/fsb_sync.sv
module fsb_sync #(
   parameter int         WIDTH   = 1,
   parameter int         STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fsb_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain[s] <= RST_VAL;
            else if (s == 0) chain[s] <= d;
            else             chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fsb_rank_dec.sv
module fsb_rank_dec
   import fsb_arb_pkg::*;
#(
   parameter bit RESERVED_LAST = 1'b1
) (
   input  logic [CODE_W-1:0] code,
   output logic [RANK_W-1:0] rank,
   output logic              reserved
);
   logic [RANK_W-1:0] base_rank;

   assign reserved  = (code == CODE_RESERVED);
   assign base_rank = speed_rank(code);

   generate
      if (RESERVED_LAST) begin : g_res_top
         // reserved sorts above every real speed: never picked over a valid code
         assign rank = reserved ? {RANK_W{1'b1}} : base_rank;
      end else begin : g_res_bottom
         assign rank = reserved ? '0 : base_rank;
      end
   endgenerate
endmodule

// File: rtl/fsb_ready_gate.sv
module fsb_ready_gate #(
   parameter int HOLD = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rdy,
   output logic unmask
);
   localparam int CNT_W = $clog2(HOLD + 1);

   generate
      if (HOLD < 1) begin : g_bad_hold
         $error("fsb_ready_gate: HOLD must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         unmask <= 1'b0;
      end else begin
         if (!rdy)                         cnt <= '0;
         else if (cnt != CNT_W'(HOLD))     cnt <= cnt + 1'b1;
         if (rdy && cnt == CNT_W'(HOLD-1)) unmask <= 1'b1;
      end
   end

   // R8
   unmask_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unmask |=> unmask);

   // R7
   unmask_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unmask) |-> $past(rdy));
endmodule

// File: rtl/fsb_speed_arbiter.sv
module fsb_speed_arbiter
   import fsb_arb_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int READY_HOLD  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_ready,
   input  logic [CODE_W-1:0] a_code,
   input  logic              a_present_n,
   input  logic [CODE_W-1:0] b_code,
   input  logic              b_present_n,
   output logic [CODE_W-1:0] bus_sel,
   output logic              a_faster,
   output logic              same_speed,
   output logic              code_err
);
   localparam int SLOT_W = CODE_W + 1;

   logic [SLOT_W-1:0] a_raw, b_raw, a_sync, b_sync;
   logic              rdy_sync, unmask;
   slot_t             sa, sb;
   logic [RANK_W-1:0] rank_a, rank_b;
   logic              res_a, res_b;
   logic [CODE_W-1:0] pick;
   logic              sel_n, eq_n, err_n;

   assign a_raw = {a_code, ~a_present_n};
   assign b_raw = {b_code, ~b_present_n};

   fsb_sync #(.WIDTH(SLOT_W), .STAGES(SYNC_STAGES), .RST_VAL({CODE_DEFAULT, 1'b0}))
      u_sync_a (.clk(clk), .rst_n(rst_n), .d(a_raw), .q(a_sync));
   fsb_sync #(.WIDTH(SLOT_W), .STAGES(SYNC_STAGES), .RST_VAL({CODE_DEFAULT, 1'b0}))
      u_sync_b (.clk(clk), .rst_n(rst_n), .d(b_raw), .q(b_sync));
   fsb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0))
      u_sync_r (.clk(clk), .rst_n(rst_n), .d(ref_ready), .q(rdy_sync));

   assign sa = a_sync;
   assign sb = b_sync;

   fsb_rank_dec u_dec_a (.code(sa.code), .rank(rank_a), .reserved(res_a));
   fsb_rank_dec u_dec_b (.code(sb.code), .rank(rank_b), .reserved(res_b));

   fsb_ready_gate #(.HOLD(READY_HOLD))
      u_gate (.clk(clk), .rst_n(rst_n), .rdy(rdy_sync), .unmask(unmask));

   always_comb begin
      pick  = CODE_DEFAULT;
      sel_n = 1'b0;
      eq_n  = 1'b0;
      case ({sa.present, sb.present})
         2'b10: pick = sa.code;
         2'b01: begin pick = sb.code; sel_n = 1'b1; end
         2'b11: begin
            sel_n = (rank_a > rank_b);
            eq_n  = (rank_a == rank_b);
            pick  = sel_n ? sb.code : sa.code;
         end
         default: ;
      endcase
      err_n = (sa.present && res_a) || (sb.present && res_b);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_sel    <= CODE_DEFAULT;
         a_faster   <= 1'b0;
         same_speed <= 1'b0;
         code_err   <= 1'b0;
      end else begin
         bus_sel    <= unmask ? pick : CODE_DEFAULT;
         a_faster   <= sel_n;
         same_speed <= eq_n;
         code_err   <= err_n;
      end
   end

   // R6
   masked_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !unmask |=> (bus_sel == CODE_DEFAULT));

   // R4
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_faster && same_speed));

   // R5
   empty_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sa.present && !sb.present) |=> (!a_faster && !same_speed));

   // R10
   empty_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sa.present && !sb.present) |=> !code_err);

   // R2
   only_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (unmask && sa.present && !sb.present) |=> (bus_sel == $past(sa.code)));
endmodule

// File: tb/tb_fsb_speed_arbiter.sv
module tb_fsb_speed_arbiter;
   localparam int HOLD = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_ready = 1'b0;
   logic [2:0] a_code = 3'b101, b_code = 3'b101;
   logic       a_present_n = 1'b1, b_present_n = 1'b1;
   logic [2:0] bus_sel;
   logic       a_faster, same_speed, code_err;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [2:0] code;
      logic       sel;
      logic       eq;
      logic       err;
      string      tag;
   } exp_t;

   exp_t sb_q[$];
   bit   drv_done = 1'b0;

   always #4 clk = ~clk;

   fsb_speed_arbiter #(.SYNC_STAGES(2), .READY_HOLD(HOLD)) dut (
      .clk(clk), .rst_n(rst_n), .ref_ready(ref_ready),
      .a_code(a_code), .a_present_n(a_present_n),
      .b_code(b_code), .b_present_n(b_present_n),
      .bus_sel(bus_sel), .a_faster(a_faster),
      .same_speed(same_speed), .code_err(code_err));

   function automatic int mhz(input logic [2:0] c);
      case (c)
         3'b101: return 100;
         3'b001: return 133;
         3'b011: return 166;
         3'b010: return 200;
         3'b000: return 266;
         3'b100: return 333;
         3'b110: return 400;
         default: return 9999;
      endcase
   endfunction

   function automatic exp_t model(input logic [2:0] a, input logic [2:0] b,
                                  input bit ahere, input bit bhere,
                                  input bit live, input string tag);
      exp_t e;
      e.code = 3'b101; e.sel = 0; e.eq = 0; e.tag = tag;
      e.err = (ahere && a == 3'b111) || (bhere && b == 3'b111);
      if (ahere && bhere) begin
         e.sel = mhz(a) > mhz(b);
         e.eq  = mhz(a) == mhz(b);
         e.code = e.sel ? b : a;
      end else if (ahere) e.code = a;
      else if (bhere) begin e.code = b; e.sel = 1; end
      if (!live) e.code = 3'b101;
      return e;
   endfunction

   task automatic compare(input exp_t e);
      checks++;
      if (bus_sel !== e.code || a_faster !== e.sel ||
          same_speed !== e.eq || code_err !== e.err) begin
         errors++;
         $display("FAIL %s: got code=%b sel=%b eq=%b err=%b, expected code=%b sel=%b eq=%b err=%b",
                  e.tag, bus_sel, a_faster, same_speed, code_err,
                  e.code, e.sel, e.eq, e.err);
      end
   endtask

   // driver: apply at falling edge, let the pipeline settle, queue the expectation
   task automatic drive(input logic [2:0] a, input logic [2:0] b,
                        input bit ahere, input bit bhere,
                        input bit live, input string tag);
      @(negedge clk);
      a_code = a; b_code = b; a_present_n = !ahere; b_present_n = !bhere;
      repeat (5) @(negedge clk);
      sb_q.push_back(model(a, b, ahere, bhere, live, tag));
   endtask

   // monitor: compare queued expectations against the outputs
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() > 0) compare(sb_q.pop_front());
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R6 reset state
      sb_q.push_back(model(3'b101, 3'b101, 0, 0, 0, "R6 reset"));
      @(negedge clk);
      rst_n = 1'b1;
      // R9 status live while masked, R6 masked code
      drive(3'b100, 3'b010, 1, 1, 0, "R9 status while masked");
      drive(3'b111, 3'b010, 1, 1, 0, "R9 err while masked");
      // R7 short ready pulse
      @(negedge clk); ref_ready = 1'b1;
      repeat (HOLD - 2) @(negedge clk);
      ref_ready = 1'b0;
      repeat (8) @(negedge clk);
      drive(3'b001, 3'b011, 1, 1, 0, "R7 short pulse keeps mask");
      // R7 qualified ready
      ref_ready = 1'b1;
      repeat (HOLD + 6) @(negedge clk);
      drive(3'b001, 3'b011, 1, 1, 1, "R7 unmask after hold");
      // R8 sticky
      ref_ready = 1'b0;
      repeat (6) @(negedge clk);
      drive(3'b011, 3'b001, 1, 1, 1, "R8 stays unmasked");
      // R1 code order versus speed order
      drive(3'b101, 3'b001, 1, 1, 1, "R1 100 vs 133");
      drive(3'b100, 3'b010, 1, 1, 1, "R1 333 vs 200");
      drive(3'b000, 3'b110, 1, 1, 1, "R1 266 vs 400");
      // R2 / R3
      drive(3'b110, 3'b101, 1, 0, 1, "R2 only A");
      drive(3'b010, 3'b100, 0, 1, 1, "R3 only B");
      // R4 equal and lower wins
      drive(3'b010, 3'b010, 1, 1, 1, "R4 equal speed");
      drive(3'b110, 3'b000, 1, 1, 1, "R4 lower wins");
      // R5 empty
      drive(3'b000, 3'b110, 0, 0, 1, "R5 no sockets");
      // R10 reserved
      drive(3'b111, 3'b011, 1, 1, 1, "R10 A reserved");
      drive(3'b001, 3'b111, 1, 1, 1, "R10 B reserved");
      drive(3'b111, 3'b000, 0, 1, 1, "R10 absent reserved no err");
      // R11 tracking latency: change, sample after SYNC_STAGES+1 edges
      @(negedge clk);
      a_code = 3'b011; b_code = 3'b100; a_present_n = 0; b_present_n = 0;
      repeat (3) @(posedge clk);
      #2;
      compare(model(3'b011, 3'b100, 1, 1, 1, "R11 latency"));
      repeat (4) @(negedge clk);
      drv_done = 1'b1;
   end

   initial begin
      fork
         wait (drv_done && sb_q.size() == 0);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: got hung run, expected completion");
         end
      join_any
      repeat (2) @(posedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule